// File: doc/BRIEF.md
# Dual-Lane Serial Audio Port

This block moves stereo audio between a three-wire serial link and a parallel sample interface. Each sample period holds a left word and a right word of `WORD_W` bits, sent most significant bit first. Two serial inputs are deserialized side by side with the same framing. One serial output is serialized with that framing. A word-select level tells which channel the current word belongs to.

Two static controls set the link. `fmt_early` picks the word-select alignment: the level changes either right on the word boundary or one bit clock before it. `slave_mode` picks who owns the timing. As master, the port divides the system clock to make the bit clock and word select. As slave, it takes both lines from outside, passes them through a synchronizer into the system clock domain and follows their edges. Serial data changes after falling bit-clock edges and is captured on rising ones.

On the parallel side, a one-cycle strobe presents all four received words once both words of a frame have arrived on both lanes. A transmit pair is written with a load pulse. The port takes it at the next frame start and acknowledges with a pulse. If no new pair was written, the last pair is sent again.

Top module: `duo_serial_audio`

## Requirements
- R1: With `fmt_early`=0, each input lane yields its left word (word select low, first in the frame) and its right word (word select high), MSB first. After the right word of a frame whose left word was also received, `rx_valid` is high for exactly one cycle, with all four words on `rx0_left`, `rx0_right`, `rx1_left` and `rx1_right`. The two lanes carry independent data.
- R2: With `fmt_early`=1, word select changes one bit clock before each word boundary. Reception and transmission align to the bit that follows the change.
- R3: `sd_out` carries the current pair MSB first, left word then right word. It changes only while the bit clock is low, so it is stable at each rising edge.
- R4: A pair written with `tx_load` is taken at the next left-word boundary, and `tx_taken` pulses for one cycle. A frame with no new write resends the previous pair and gives no `tx_taken` pulse.
- R5: With `slave_mode`=0, `sck_out` has a period of 2*`HALF_DIV` system clocks. `ws_out` changes only on falling edges of `sck_out` and stays high for 16 bit clocks (`WORD_W`) per frame.
- R6: With `slave_mode`=0, a partner that frames its data on `sck_out`/`ws_out` exchanges correct words in both alignments.
- R7: With `slave_mode`=1, `sck_out` and `ws_out` are held low, and framing follows `sck_in`/`ws_in`.
- R8: During reset, `rx_valid`, `tx_taken`, `sd_out`, `sck_out` and `ws_out` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fmt_early | input | 1 | 1: word select leads the boundary by one bit clock |
| slave_mode | input | 1 | 1: bit clock and word select come from outside |
| sck_in | input | 1 | External bit clock (slave) |
| ws_in | input | 1 | External word select (slave) |
| sd_in0 | input | 1 | Serial data input, lane 0 |
| sd_in1 | input | 1 | Serial data input, lane 1 |
| sck_out | output | 1 | Generated bit clock (master) |
| ws_out | output | 1 | Generated word select (master) |
| sd_out | output | 1 | Serial data output |
| rx_valid | output | 1 | One-cycle strobe: a full frame was received |
| rx0_left | output | WORD_W | Lane 0 left word |
| rx0_right | output | WORD_W | Lane 0 right word |
| rx1_left | output | WORD_W | Lane 1 left word |
| rx1_right | output | WORD_W | Lane 1 right word |
| tx_left | input | WORD_W | Left word to send |
| tx_right | input | WORD_W | Right word to send |
| tx_load | input | 1 | Write strobe for the transmit pair |
| tx_taken | output | 1 | Pulse when a written pair enters a frame |

## Verification
In slave mode, the bench drives frames in both alignments. Each lane and each channel gets a different word, so a swapped lane, a swapped channel or a one-bit slip shows up as a wrong value. A second frame with no transmit write separates resending the held pair from sending stale or zero data. In master mode, the bench measures the bit-clock period and the length of the high word-select phase. It then acts as a partner in each alignment, which shows whether the port and its own generated timing agree on where words begin.

// File: rtl/dsa_pkg.sv
package dsa_pkg;
   typedef enum logic {
      SIDE_LEFT  = 1'b0,
      SIDE_RIGHT = 1'b1
   } side_e;
endpackage

// File: rtl/dsa_sync.sv
module dsa_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/dsa_clkgen.sv
module dsa_clkgen #(
   parameter int WORD_W   = 16,
   parameter int HALF_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic fmt_early,
   output logic sck,
   output logic ws
);
   localparam int FRAME = 2 * WORD_W;
   localparam int BW    = $clog2(FRAME);
   localparam int DW    = $clog2(HALF_DIV);

   logic [DW-1:0] div;
   logic [BW-1:0] bidx, nb, nb2;

   assign nb  = (bidx == BW'(FRAME - 1)) ? '0 : bidx + 1'b1;
   assign nb2 = (nb   == BW'(FRAME - 1)) ? '0 : nb + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div  <= '0;
         sck  <= 1'b0;
         ws   <= 1'b0;
         bidx <= BW'(FRAME - 1);
      end else if (!en) begin
         div  <= '0;
         sck  <= 1'b0;
         ws   <= 1'b0;
         bidx <= BW'(FRAME - 1);
      end else if (div == DW'(HALF_DIV - 1)) begin
         div <= '0;
         sck <= ~sck;
         if (sck) begin
            bidx <= nb;
            ws   <= fmt_early ? (nb2 >= BW'(WORD_W)) : (nb >= BW'(WORD_W));
         end
      end else begin
         div <= div + 1'b1;
      end
   end
endmodule

// File: rtl/dsa_framer.sv
module dsa_framer
   import dsa_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  fmt_early,
   input  logic  line_sck,
   input  logic  line_ws,
   output logic  rx_clear,
   output logic  rx_shift,
   output logic  rx_end,
   output side_e rx_end_side,
   output logic  tx_bound,
   output side_e tx_side,
   output logic  tx_shift
);
   localparam int CW = $clog2(WORD_W + 1);

   logic          sck_d, rise, fall;
   logic          rh1, rh2, fh1, fh2;
   logic          rcur, rlast, tcur, tlast;
   logic          started;
   logic [CW-1:0] cnt, cnt_nx;

   assign rise  = line_sck & ~sck_d;
   assign fall  = ~line_sck & sck_d;
   assign rcur  = fmt_early ? rh1 : line_ws;
   assign rlast = fmt_early ? rh2 : rh1;
   assign tcur  = fmt_early ? fh1 : line_ws;
   assign tlast = fmt_early ? fh2 : fh1;

   assign rx_clear = rise && (rcur != rlast);
   assign rx_shift = rx_clear || (rise && started && cnt != CW'(WORD_W));
   assign cnt_nx   = rx_clear ? CW'(1) : cnt + 1'b1;

   assign tx_bound = fall && (tcur != tlast);
   assign tx_side  = side_e'(tcur);
   assign tx_shift = fall && !tx_bound;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d       <= 1'b0;
         rh1         <= 1'b0;
         rh2         <= 1'b0;
         fh1         <= 1'b0;
         fh2         <= 1'b0;
         started     <= 1'b0;
         cnt         <= '0;
         rx_end      <= 1'b0;
         rx_end_side <= SIDE_LEFT;
      end else begin
         sck_d  <= line_sck;
         rx_end <= rx_shift && (cnt_nx == CW'(WORD_W));
         if (rise) begin
            rh1 <= line_ws;
            rh2 <= rh1;
         end
         if (fall) begin
            fh1 <= line_ws;
            fh2 <= fh1;
         end
         if (rx_clear) started <= 1'b1;
         if (rx_shift) begin
            cnt         <= cnt_nx;
            rx_end_side <= side_e'(rcur);
         end
      end
   end
endmodule

// File: rtl/dsa_rx_lane.sv
module dsa_rx_lane
   import dsa_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              shift,
   input  logic              sd,
   input  logic              word_end,
   input  side_e             end_side,
   output logic [WORD_W-1:0] left,
   output logic [WORD_W-1:0] right
);
   logic [WORD_W-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh    <= '0;
         left  <= '0;
         right <= '0;
      end else begin
         if (clear)      sh <= {{(WORD_W-1){1'b0}}, sd};
         else if (shift) sh <= {sh[WORD_W-2:0], sd};
         if (word_end) begin
            if (end_side == SIDE_LEFT) left  <= sh;
            else                       right <= sh;
         end
      end
   end
endmodule

// File: rtl/dsa_tx_engine.sv
module dsa_tx_engine
   import dsa_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bound,
   input  side_e             side,
   input  logic              shift,
   input  logic [WORD_W-1:0] wr_left,
   input  logic [WORD_W-1:0] wr_right,
   input  logic              wr_load,
   output logic              sd,
   output logic              taken
);
   logic [WORD_W-1:0] hold_l, hold_r, fr_l, fr_r, sh;
   logic              pending;

   assign sd = sh[WORD_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_l  <= '0;
         hold_r  <= '0;
         fr_l    <= '0;
         fr_r    <= '0;
         sh      <= '0;
         pending <= 1'b0;
         taken   <= 1'b0;
      end else begin
         taken <= 1'b0;
         if (bound) begin
            if (side == SIDE_LEFT) begin
               if (pending) begin
                  fr_l  <= hold_l;
                  fr_r  <= hold_r;
                  sh    <= hold_l;
                  taken <= 1'b1;
               end else begin
                  sh <= fr_l;
               end
            end else begin
               sh <= fr_r;
            end
         end else if (shift) begin
            sh <= {sh[WORD_W-2:0], 1'b0};
         end
         if (wr_load) begin
            hold_l  <= wr_left;
            hold_r  <= wr_right;
            pending <= 1'b1;
         end else if (bound && side == SIDE_LEFT) begin
            pending <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/duo_serial_audio.sv
module duo_serial_audio
   import dsa_pkg::*;
#(
   parameter int WORD_W      = 16,
   parameter int HALF_DIV    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fmt_early,
   input  logic              slave_mode,
   input  logic              sck_in,
   input  logic              ws_in,
   input  logic              sd_in0,
   input  logic              sd_in1,
   output logic              sck_out,
   output logic              ws_out,
   output logic              sd_out,
   output logic              rx_valid,
   output logic [WORD_W-1:0] rx0_left,
   output logic [WORD_W-1:0] rx0_right,
   output logic [WORD_W-1:0] rx1_left,
   output logic [WORD_W-1:0] rx1_right,
   input  logic [WORD_W-1:0] tx_left,
   input  logic [WORD_W-1:0] tx_right,
   input  logic              tx_load,
   output logic              tx_taken
);
   localparam int NUM_LANES = 2;
   localparam int SW        = 2 + NUM_LANES;

   if (WORD_W < 2)      begin : g_bad_word  $error("WORD_W must be at least 2");      end
   if (HALF_DIV < 4)    begin : g_bad_div   $error("HALF_DIV must be at least 4");    end
   if (SYNC_STAGES < 2) begin : g_bad_sync  $error("SYNC_STAGES must be at least 2"); end

   logic [SW-1:0]        raw, syn;
   logic                 m_sck, m_ws, line_sck, line_ws;
   logic                 rx_clear, rx_shift, rx_end, tx_bound, tx_shift;
   side_e                rx_end_side, tx_side;
   logic [NUM_LANES-1:0] lane_sd;
   logic [WORD_W-1:0]    lane_l [NUM_LANES];
   logic [WORD_W-1:0]    lane_r [NUM_LANES];
   logic                 left_got;

   assign raw = {sck_in, ws_in, sd_in1, sd_in0};

   dsa_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
   );

   dsa_clkgen #(.WORD_W(WORD_W), .HALF_DIV(HALF_DIV)) u_clkgen (
      .clk(clk), .rst_n(rst_n), .en(!slave_mode), .fmt_early(fmt_early),
      .sck(m_sck), .ws(m_ws)
   );

   assign sck_out  = m_sck;
   assign ws_out   = m_ws;
   assign line_sck = slave_mode ? syn[SW-1] : m_sck;
   assign line_ws  = slave_mode ? syn[SW-2] : m_ws;
   assign lane_sd  = syn[NUM_LANES-1:0];

   dsa_framer #(.WORD_W(WORD_W)) u_framer (
      .clk(clk), .rst_n(rst_n), .fmt_early(fmt_early),
      .line_sck(line_sck), .line_ws(line_ws),
      .rx_clear(rx_clear), .rx_shift(rx_shift), .rx_end(rx_end),
      .rx_end_side(rx_end_side), .tx_bound(tx_bound), .tx_side(tx_side),
      .tx_shift(tx_shift)
   );

   for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      dsa_rx_lane #(.WORD_W(WORD_W)) u_lane (
         .clk(clk), .rst_n(rst_n), .clear(rx_clear), .shift(rx_shift),
         .sd(lane_sd[g]), .word_end(rx_end), .end_side(rx_end_side),
         .left(lane_l[g]), .right(lane_r[g])
      );
   end

   assign rx0_left  = lane_l[0];
   assign rx0_right = lane_r[0];
   assign rx1_left  = lane_l[1];
   assign rx1_right = lane_r[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_got <= 1'b0;
         rx_valid <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         if (rx_end) begin
            if (rx_end_side == SIDE_LEFT) begin
               left_got <= 1'b1;
            end else begin
               left_got <= 1'b0;
               rx_valid <= left_got;
            end
         end
      end
   end

   dsa_tx_engine #(.WORD_W(WORD_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .bound(tx_bound), .side(tx_side),
      .shift(tx_shift), .wr_left(tx_left), .wr_right(tx_right),
      .wr_load(tx_load), .sd(sd_out), .taken(tx_taken)
   );
endmodule

// File: rtl/dsa_checks.sv
module dsa_checks (
   input logic clk,
   input logic rst_n,
   input logic slave_mode,
   input logic sck_out,
   input logic ws_out,
   input logic sd_out,
   input logic rx_valid,
   input logic tx_taken
);
   AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);                                             // R1

   AST_TAKEN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_taken |=> !tx_taken);                                             // R4

   AST_SLAVE_LINES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (slave_mode && $past(slave_mode)) |-> (!sck_out && !ws_out));        // R7

   AST_WS_ON_SCK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (!slave_mode && $past(!slave_mode) && !$stable(ws_out)) |-> $fell(sck_out)); // R5

   AST_SD_WHILE_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!slave_mode && $past(!slave_mode) && !$stable(sd_out)) |-> !sck_out); // R3
endmodule

bind duo_serial_audio dsa_checks u_chk (
   .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode), .sck_out(sck_out),
   .ws_out(ws_out), .sd_out(sd_out), .rx_valid(rx_valid), .tx_taken(tx_taken)
);

// File: tb/sim_duo_serial_audio.sv
`timescale 1ns/1ps
module sim_duo_serial_audio;
   localparam int W  = 16;
   localparam int HD = 4;
   localparam int SH = 8;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n, fmt_early, slave_mode, sck_in, ws_in, sd_in0, sd_in1;
   logic sck_out, ws_out, sd_out, rx_valid, tx_load, tx_taken;
   logic [W-1:0] rx0_left, rx0_right, rx1_left, rx1_right, tx_left, tx_right;

   duo_serial_audio #(.WORD_W(W), .HALF_DIV(HD), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .fmt_early(fmt_early), .slave_mode(slave_mode),
      .sck_in(sck_in), .ws_in(ws_in), .sd_in0(sd_in0), .sd_in1(sd_in1),
      .sck_out(sck_out), .ws_out(ws_out), .sd_out(sd_out), .rx_valid(rx_valid),
      .rx0_left(rx0_left), .rx0_right(rx0_right), .rx1_left(rx1_left),
      .rx1_right(rx1_right), .tx_left(tx_left), .tx_right(tx_right),
      .tx_load(tx_load), .tx_taken(tx_taken)
   );

   int n_chk = 0, n_bad = 0, vcnt = 0, tkcnt = 0;
   logic [W-1:0] c0l, c0r, c1l, c1r;
   logic [31:0]  txcap;

   always @(negedge clk) begin
      if (rx_valid) begin
         vcnt++;
         c0l = rx0_left;  c0r = rx0_right;
         c1l = rx1_left;  c1r = rx1_right;
      end
      if (tx_taken) tkcnt++;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic fmt, input logic slv);
      rst_n = 1'b0; fmt_early = fmt; slave_mode = slv;
      sck_in = 1'b1; ws_in = 1'b0; sd_in0 = 1'b0; sd_in1 = 1'b0;
      tx_load = 1'b0; tx_left = '0; tx_right = '0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic load_tx(input logic [W-1:0] l, input logic [W-1:0] r);
      @(negedge clk);
      tx_left = l; tx_right = r; tx_load = 1'b1;
      @(negedge clk);
      tx_load = 1'b0;
   endtask

   task automatic slave_frame(input logic fmt, input logic [W-1:0] l0, input logic [W-1:0] r0,
                              input logic [W-1:0] l1, input logic [W-1:0] r1);
      for (int i = 0; i < 2*W; i++) begin
         sck_in = 1'b0;
         ws_in  = fmt ? (((i + 1) % (2*W)) >= W) : (i >= W);
         sd_in0 = (i < W) ? l0[W-1-i] : r0[2*W-1-i];
         sd_in1 = (i < W) ? l1[W-1-i] : r1[2*W-1-i];
         repeat (SH) @(negedge clk);
         sck_in = 1'b1;
         repeat (SH) @(negedge clk);
         txcap[2*W-1-i] = sd_out;
      end
   endtask

   task automatic t_reset;
      rst_n = 1'b0; fmt_early = 1'b0; slave_mode = 1'b0;
      sck_in = 1'b1; ws_in = 1'b0; sd_in0 = 1'b0; sd_in1 = 1'b0;
      tx_load = 1'b0; tx_left = '0; tx_right = '0;
      repeat (4) @(negedge clk);
      chk("R8 rx_valid", {31'd0, rx_valid}, 32'd0);
      chk("R8 tx_taken", {31'd0, tx_taken}, 32'd0);
      chk("R8 sd_out",   {31'd0, sd_out},   32'd0);
      chk("R8 sck_out/ws_out", {30'd0, sck_out, ws_out}, 32'd0);
   endtask

   task automatic t_slave_std;
      do_reset(1'b0, 1'b1);
      load_tx(16'hA5C3, 16'h0F1E);
      slave_frame(1'b0, 16'h0, 16'h0, 16'h0, 16'h0);
      vcnt = 0; tkcnt = 0;
      slave_frame(1'b0, 16'h1234, 16'h8001, 16'hBEEF, 16'h7F5A);
      repeat (4) @(negedge clk);
      chk("R1 valid count", vcnt, 1);
      chk("R1 lane0 left",  {16'd0, c0l}, 32'h1234);
      chk("R1 lane0 right", {16'd0, c0r}, 32'h8001);
      chk("R1 lane1 left",  {16'd0, c1l}, 32'hBEEF);
      chk("R1 lane1 right", {16'd0, c1r}, 32'h7F5A);
      chk("R3 serial out pair", txcap, 32'hA5C3_0F1E);
      chk("R4 taken once", tkcnt, 1);
      chk("R7 master lines idle", {30'd0, sck_out, ws_out}, 32'd0);
   endtask

   task automatic t_slave_resend;
      vcnt = 0; tkcnt = 0;
      slave_frame(1'b0, 16'h00FF, 16'hFF00, 16'hC3C3, 16'h3C3C);
      repeat (4) @(negedge clk);
      chk("R1 lane0 left pattern2",  {16'd0, c0l}, 32'h00FF);
      chk("R1 lane1 right pattern2", {16'd0, c1r}, 32'h3C3C);
      chk("R4 resend previous pair", txcap, 32'hA5C3_0F1E);
      chk("R4 no taken without load", tkcnt, 0);
   endtask

   task automatic t_slave_early;
      do_reset(1'b1, 1'b1);
      load_tx(16'h6D21, 16'hE00B);
      slave_frame(1'b1, 16'h0, 16'h0, 16'h0, 16'h0);
      vcnt = 0; tkcnt = 0;
      slave_frame(1'b1, 16'h8421, 16'h0F0F, 16'h5555, 16'hAAAA);
      repeat (4) @(negedge clk);
      chk("R2 valid count", vcnt, 1);
      chk("R2 lane0 left",  {16'd0, c0l}, 32'h8421);
      chk("R2 lane0 right", {16'd0, c0r}, 32'h0F0F);
      chk("R2 lane1 left",  {16'd0, c1l}, 32'h5555);
      chk("R2 lane1 right", {16'd0, c1r}, 32'hAAAA);
      chk("R2 serial out pair", txcap, 32'h6D21_E00B);
      chk("R4 taken early format", tkcnt, 1);
   endtask

   task automatic t_master(input logic fmt, input logic [W-1:0] l0, input logic [W-1:0] r0,
                           input logic [W-1:0] l1, input logic [W-1:0] r1,
                           input logic [W-1:0] tl, input logic [W-1:0] tr);
      longint t0, t1;
      int n;
      do_reset(fmt, 1'b0);
      load_tx(tl, tr);
      @(posedge sck_out); t0 = $time;
      @(posedge sck_out); t1 = $time;
      chk("R5 sck period ns", 32'(t1 - t0), 32'(2*HD*5));
      @(posedge ws_out);
      n = 0;
      while (ws_out) begin
         @(posedge clk); #1;
         n++;
      end
      chk("R5 ws high clocks", n, 2*HD*W);
      @(negedge ws_out);
      if (fmt) @(negedge sck_out);
      vcnt = 0;
      for (int i = 0; i < 2*W; i++) begin
         #1;
         sd_in0 = (i < W) ? l0[W-1-i] : r0[2*W-1-i];
         sd_in1 = (i < W) ? l1[W-1-i] : r1[2*W-1-i];
         @(posedge sck_out); #1;
         txcap[2*W-1-i] = sd_out;
         if (i < 2*W-1) @(negedge sck_out);
      end
      repeat (10) @(negedge clk);
      chk("R6 master valid count", vcnt, 1);
      chk("R6 master lane0", {c0l, c0r}, {l0, r0});
      chk("R6 master lane1", {c1l, c1r}, {l1, r1});
      chk("R6 master serial out", txcap, {tl, tr});
   endtask

   task automatic finish_run;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #1_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_run();
   end

   initial begin
      t_reset();
      t_slave_std();
      t_slave_resend();
      t_slave_early();
      t_master(1'b0, 16'hCAFE, 16'h1357, 16'h2468, 16'hF00D, 16'h9A8B, 16'h0102);
      t_master(1'b1, 16'h7E81, 16'hFFFF, 16'h0001, 16'h8000, 16'h3210, 16'hC0DE);
      finish_run();
   end
endmodule